// File: doc/BRIEF.md
# Soft Mute Ramp with Zero Detect

This block is a per-sample gain stage for a stereo audio path. Each strobed pair of signed left/right samples is multiplied by a gain taken from a table of 104 levels spaced 1 dB apart. Level 0 is unity and level 103 is full cut. An active-low mute control sets the direction of travel. While it is low, every sample strobe moves the gain one level toward full cut. While it is high, every strobe moves the gain one level back toward unity. A change of direction part way through a ramp continues from the current level.

A separate watcher counts consecutive strobes on which both channels are exactly zero. After a long enough run it raises an analog-mute request. The same request is raised whenever the control asks for mute and the digital gain has reached full cut. The block sits between the serial-port deserializer and the interpolation filter, and its request drives the downstream output-stage mute switch.

Top module: `smr_soft_mute`

## Requirements
- R1: A synchronous active-low reset leaves the gain at full cut (level 103) and treats the control as muting. In the cycle after reset releases, `out_stb` is 0, `out_l` and `out_r` are 0, `ramp_busy` is 0 and `amute_req` is 1.
- R2: With `mute_n` low, each `smp_stb` pulse raises the gain level by one (1 dB more attenuation) until level 103.
- R3: With `mute_n` high, each `smp_stb` pulse lowers the gain level by one (1 dB less attenuation) until level 0.
- R4: A complete ramp passes through all 104 levels. Starting at one end, `ramp_busy` falls after exactly 103 strobes.
- R5: The coefficient for level k is c(0)=65536 and c(k)=(c(k-1)*58409+32768)>>16 for 0<k<103, with c(103)=0. Each output sample is (x*c+32768)>>>16, using the level in force before that strobe, saturated to the sample width. It appears on `out_l`/`out_r` with `out_stb` high in the cycle after the strobe.
- R6: At level 0 each output equals its input exactly. At level 103 both outputs are 0.
- R7: If `mute_n` reverses during a ramp, the next strobe steps from the current level in the new direction. The ramp does not restart from an end.
- R8: `amute_req` is high whenever the control asks for mute and the gain is at level 103.
- R9: After 1024 consecutive strobes with both samples equal to 0, `amute_req` is high in the next cycle. After 1023 such strobes it is still low, unless R8 holds.
- R10: A strobe carrying a non-zero sample on either channel restarts the zero run, and the zero-run request drops in the next cycle.
- R11: `ramp_busy` is high exactly while the gain level differs from the end point that the control selects.
- R12: The gain level changes only on a strobe. A control change without strobes moves no level, and the sample after it is scaled by the unchanged gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mute_n | input | 1 | Mute control, low = ramp to cut, high = ramp to unity |
| smp_stb | input | 1 | One-cycle pulse marking a new sample pair |
| smp_l | input | DW | Left sample, two's complement |
| smp_r | input | DW | Right sample, two's complement |
| out_stb | output | 1 | Scaled pair valid, one cycle after `smp_stb` |
| out_l | output | DW | Scaled left sample |
| out_r | output | DW | Scaled right sample |
| ramp_busy | output | 1 | Gain level still moving toward its end point |
| amute_req | output | 1 | Request to engage the analog mute |

## Verification
The bench reverses the control halfway down a ramp. A design that restarted from an end point would produce a sudden jump in output gain. The zero run is probed at 1023 and 1024 strobes, and then broken by a value on only one channel. A counter that was off by one, or that tested only one channel, would raise or drop the request at the wrong strobe. Full-scale positive and negative samples at unity check for rounding or saturation that alters an exact pass-through. Idle cycles after a control change check that the gain does not step without a strobe.

// File: rtl/smr_pkg.sv
// Shared constants and the gain-law function for the soft mute ramp.
// Assumes a Q1.16 unsigned coefficient format where 65536 means unity.
package smr_pkg;
    localparam int FRAC     = 16;
    localparam int CW       = FRAC + 1;
    localparam int STEP_MUL = 58409;   // 10^(-1/20) in Q.16

    // Coefficient for level k: repeated 1 dB scaling, last level forced to zero.
    function automatic logic [CW-1:0] step_coef(input int k, input int last);
        longint c;
        c = longint'(1) << FRAC;
        if (k >= last) return '0;
        for (int i = 1; i <= k; i++)
            c = (c * STEP_MUL + (longint'(1) << (FRAC - 1))) >>> FRAC;
        return CW'(c);
    endfunction
endpackage

// File: rtl/smr_gain_table.sv
// Gain lookup: maps a level index to its linear coefficient.
// Assumes idx never exceeds STEPS-1 (guaranteed by the step controller).
module smr_gain_table
    import smr_pkg::*;
#(
    parameter int STEPS = 104,
    localparam int IW   = $clog2(STEPS)
) (
    input  logic [IW-1:0] idx,
    output logic [CW-1:0] coef
);
    logic [CW-1:0] tbl [STEPS];

    for (genvar k = 0; k < STEPS; k++) begin : g_lvl
        assign tbl[k] = step_coef(k, STEPS - 1);
    end

    // Select the coefficient for the current level.
    always_comb coef = tbl[idx];
endmodule

// File: rtl/smr_step_ctrl.sv
// Step controller: registers the mute control and walks the level index
// one step per sample strobe toward the selected end point.
// Assumes the mute control is already synchronous to clk.
module smr_step_ctrl #(
    parameter int STEPS = 104,
    localparam int IW   = $clog2(STEPS),
    localparam logic [IW-1:0] LAST = IW'(STEPS - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mute_n,
    input  logic          strobe,
    output logic [IW-1:0] idx,
    output logic          muting,
    output logic          busy,
    output logic          at_cut
);
    logic mute_q;

    // Register the control and step the level on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_q <= 1'b0;
            idx    <= LAST;
        end else begin
            mute_q <= mute_n;
            if (strobe) begin
                if (mute_q && idx != '0)
                    idx <= idx - 1'b1;
                else if (!mute_q && idx != LAST)
                    idx <= idx + 1'b1;
            end
        end
    end

    // Derive status from the level and the selected end point.
    always_comb begin
        muting = !mute_q;
        at_cut = (idx == LAST);
        busy   = mute_q ? (idx != '0) : (idx != LAST);
    end
endmodule

// File: rtl/smr_scale_ch.sv
// One channel scaler: signed sample times unsigned coefficient, round
// half up, saturate, register on strobe.
// Assumes coef <= 2^FRAC, so saturation guards only against misuse.
module smr_scale_ch
    import smr_pkg::*;
#(
    parameter int DW = 24,
    localparam int PW = DW + CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [DW-1:0] sample,
    input  logic [CW-1:0] coef,
    output logic [DW-1:0] scaled
);
    localparam logic signed [PW-1:0] HI  = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] LO  = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

    logic signed [PW-1:0] a_ext, c_ext, prod, rnd;
    logic        [DW-1:0] sat;

    // Multiply, round and clamp.
    always_comb begin
        a_ext = {{(PW-DW){sample[DW-1]}}, sample};
        c_ext = {{(PW-CW){1'b0}}, coef};
        prod  = a_ext * c_ext;
        rnd   = (prod + HALF) >>> FRAC;
        if (rnd > HI)      sat = HI[DW-1:0];
        else if (rnd < LO) sat = LO[DW-1:0];
        else               sat = rnd[DW-1:0];
    end

    // Capture the scaled sample when a strobe arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)      scaled <= '0;
        else if (strobe) scaled <= sat;
    end
endmodule

// File: rtl/smr_zero_watch.sv
// Zero-run watcher: counts strobes whose two samples are both zero and
// flags a completed run; any non-zero sample restarts the count.
// Assumes RUN fits the counter width derived below.
module smr_zero_watch #(
    parameter int DW  = 24,
    parameter int RUN = 1024,
    localparam int CNTW = $clog2(RUN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [DW-1:0] smp_l,
    input  logic [DW-1:0] smp_r,
    output logic          hit
);
    logic [CNTW-1:0] cnt;

    // Count the zero run, saturating at RUN.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (strobe) begin
            if (smp_l != '0 || smp_r != '0) cnt <= '0;
            else if (cnt != CNTW'(RUN))     cnt <= cnt + 1'b1;
        end
    end

    // Flag a completed run.
    always_comb hit = (cnt == CNTW'(RUN));
endmodule

// File: rtl/smr_soft_mute.sv
// Stereo soft mute: 1 dB-per-sample gain ramp driven by an active-low
// control, plus an analog-mute request from full cut or a long zero run.
// Assumes smp_stb pulses no more often than every other clock is not
// required; one strobe per clock is accepted.
module smr_soft_mute
    import smr_pkg::*;
#(
    parameter int DW       = 24,
    parameter int STEPS    = 104,
    parameter int ZERO_RUN = 1024,
    localparam int IW      = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mute_n,
    input  logic          smp_stb,
    input  logic [DW-1:0] smp_l,
    input  logic [DW-1:0] smp_r,
    output logic          out_stb,
    output logic [DW-1:0] out_l,
    output logic [DW-1:0] out_r,
    output logic          ramp_busy,
    output logic          amute_req
);
    logic [IW-1:0]  gain_idx;
    logic [CW-1:0]  coef;
    logic           muting, at_cut, zero_hit;
    logic [DW-1:0]  ch_in  [2];
    logic [DW-1:0]  ch_out [2];

    smr_step_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mute_n(mute_n), .strobe(smp_stb),
        .idx(gain_idx), .muting(muting), .busy(ramp_busy), .at_cut(at_cut)
    );

    smr_gain_table #(.STEPS(STEPS)) u_tbl (.idx(gain_idx), .coef(coef));

    assign ch_in[0] = smp_l;
    assign ch_in[1] = smp_r;

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        smr_scale_ch #(.DW(DW)) u_scale (
            .clk(clk), .rst_n(rst_n), .strobe(smp_stb),
            .sample(ch_in[ch]), .coef(coef), .scaled(ch_out[ch])
        );
    end

    smr_zero_watch #(.DW(DW), .RUN(ZERO_RUN)) u_zero (
        .clk(clk), .rst_n(rst_n), .strobe(smp_stb),
        .smp_l(smp_l), .smp_r(smp_r), .hit(zero_hit)
    );

    // Delay the strobe to line up with the registered samples.
    always_ff @(posedge clk) begin
        if (!rst_n) out_stb <= 1'b0;
        else        out_stb <= smp_stb;
    end

    // Drive the outputs and combine the two analog-mute causes.
    always_comb begin
        out_l     = ch_out[0];
        out_r     = ch_out[1];
        amute_req = zero_hit | (muting & at_cut);
    end
endmodule

// File: rtl/smr_soft_mute_chk.sv
// Property checker for smr_soft_mute, attached by bind.
// Assumes it observes the top's level index and zero-run flag.
module smr_soft_mute_chk #(
    parameter int DW    = 24,
    parameter int STEPS = 104,
    localparam int IW   = $clog2(STEPS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_stb,
    input logic [DW-1:0] smp_l,
    input logic [DW-1:0] smp_r,
    input logic          out_stb,
    input logic [DW-1:0] out_l,
    input logic [DW-1:0] out_r,
    input logic          ramp_busy,
    input logic [IW-1:0] idx,
    input logic          zero_hit
);
    localparam logic [IW-1:0] LAST = IW'(STEPS - 1);

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (idx == $past(idx) || idx == $past(idx) + 1'b1 || idx + 1'b1 == $past(idx)));
    a_r12_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(idx));
    a_r6_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && idx == '0) |=> (out_l == $past(smp_l) && out_r == $past(smp_r)));
    a_r6_full_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && idx == LAST) |=> (out_l == '0 && out_r == '0));
    a_r11_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
        !ramp_busy |=> $stable(idx));
    a_r10_run_break: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && (smp_l != '0 || smp_r != '0)) |=> !zero_hit);
    a_r5_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> out_stb);
    a_r5_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> !out_stb);
endmodule

bind smr_soft_mute smr_soft_mute_chk #(.DW(DW), .STEPS(STEPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
    .out_stb(out_stb), .out_l(out_l), .out_r(out_r), .ramp_busy(ramp_busy),
    .idx(gain_idx), .zero_hit(zero_hit)
);

// File: tb/smr_soft_mute_bench.sv
module smr_soft_mute_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 24;
    localparam int LAST = 103;
    localparam int RUN  = 1024;

    logic clk = 1'b0, rst_n = 1'b0, mute_n = 1'b0, smp_stb = 1'b0;
    logic [DW-1:0] smp_l = '0, smp_r = '0;
    logic out_stb, ramp_busy, amute_req;
    logic [DW-1:0] out_l, out_r;

    int n_run = 0, n_fail = 0;
    int m_idx = LAST;
    bit m_muting = 1'b1;
    int m_zero = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smr_soft_mute u_smr_soft_mute (
        .clk(clk), .rst_n(rst_n), .mute_n(mute_n), .smp_stb(smp_stb),
        .smp_l(smp_l), .smp_r(smp_r), .out_stb(out_stb), .out_l(out_l),
        .out_r(out_r), .ramp_busy(ramp_busy), .amute_req(amute_req)
    );

    // Stimulus table: {mute_n, left, right}
    localparam logic [2*DW:0] VEC [16] = '{
        {1'b1, 24'h7FFFFF, 24'h800000}, {1'b1, 24'h123456, 24'hFEDCBA},
        {1'b1, 24'h000001, 24'hFFFFFF}, {1'b1, 24'h400000, 24'hC00000},
        {1'b1, 24'h7FFFFF, 24'h7FFFFF}, {1'b1, 24'h000000, 24'h2AAAAA},
        {1'b0, 24'h555555, 24'hAAAAAA}, {1'b0, 24'h7FFFFF, 24'h800000},
        {1'b0, 24'h0F0F0F, 24'hF0F0F0}, {1'b1, 24'h800000, 24'h7FFFFF},
        {1'b1, 24'h00FFFF, 24'hFF0001}, {1'b1, 24'h3FFFFF, 24'hC00001},
        {1'b1, 24'h000100, 24'h000000}, {1'b0, 24'h7FFFFE, 24'h800001},
        {1'b1, 24'h654321, 24'h9ABCDF}, {1'b1, 24'h7FFFFF, 24'h800000}
    };

    // Coefficient per the gain law of R5.
    function automatic longint coef_of(input int k);
        longint c = 65536;
        if (k >= LAST) return 0;
        for (int i = 1; i <= k; i++) c = (c * 58409 + 32768) >>> 16;
        return c;
    endfunction

    function automatic logic [DW-1:0] scale(input logic [DW-1:0] x, input int k);
        longint v;
        v = (longint'($signed(x)) * coef_of(k) + 32768) >>> 16;
        if (v > 64'sd8388607)  v = 8388607;
        if (v < -64'sd8388608) v = -8388608;
        return v[DW-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic set_mute(input logic v);
        mute_n   = v;
        m_muting = !v;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Send one pair and check every output against the model.
    task automatic send(input logic [DW-1:0] l, input logic [DW-1:0] r, input string req);
        logic [DW-1:0] el, er;
        bit eb, ea;
        el = scale(l, m_idx);
        er = scale(r, m_idx);
        if (m_muting && m_idx != LAST) m_idx++;
        else if (!m_muting && m_idx != 0) m_idx--;
        if (l != 0 || r != 0) m_zero = 0;
        else if (m_zero != RUN) m_zero++;
        eb = m_muting ? (m_idx != LAST) : (m_idx != 0);
        ea = (m_zero == RUN) || (m_muting && m_idx == LAST);
        smp_l = l; smp_r = r; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        chk(out_stb == 1'b1, "R5", out_stb, 1);
        chk(out_l == el, req, out_l, el);
        chk(out_r == er, req, out_r, er);
        chk(ramp_busy == eb, "R11", ramp_busy, eb);
        chk(amute_req == ea, "R8/R9", amute_req, ea);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_stb == 0, "R1", out_stb, 0);
        chk(out_l == 0 && out_r == 0, "R1", out_l, 0);
        chk(ramp_busy == 0, "R1", ramp_busy, 0);
        chk(amute_req == 1, "R1", amute_req, 1);

        // Table walk (includes reversals, R7)
        foreach (VEC[i]) begin
            if (VEC[i][2*DW] != mute_n) set_mute(VEC[i][2*DW]);
            send(VEC[i][2*DW-1:DW], VEC[i][DW-1:0], "R7");
        end

        // Drive to full cut (R2), then full ramp up (R3, R4)
        set_mute(1'b0);
        while (m_idx != LAST) send(24'h400000, 24'hC00000, "R2");
        set_mute(1'b1);
        chk(ramp_busy == 1, "R11", ramp_busy, 1);
        cnt = 0;
        do begin
            send(24'h7FFFFF, 24'h800000, "R3");
            cnt++;
        end while (ramp_busy && cnt < 200);
        chk(cnt == 103, "R4", cnt, 103);

        // Unity pass-through of extremes (R6)
        send(24'h7FFFFF, 24'h800000, "R6");
        chk(out_l == 24'h7FFFFF && out_r == 24'h800000, "R6", out_l, 24'h7FFFFF);

        // Full ramp down, analog mute at the end (R2, R8)
        set_mute(1'b0);
        cnt = 0;
        do begin
            send(24'h2468AC, 24'hDB9754, "R2");
            cnt++;
        end while (ramp_busy && cnt < 200);
        chk(cnt == 103, "R4", cnt, 103);
        chk(amute_req == 1, "R8", amute_req, 1);
        send(24'h7FFFFF, 24'h800000, "R6");
        chk(out_l == 0 && out_r == 0, "R6", out_l, 0);

        // Mid-ramp reversal (R7)
        set_mute(1'b1);
        repeat (40) send(24'h300000, 24'hD00000, "R7");
        set_mute(1'b0);
        repeat (3) send(24'h300000, 24'hD00000, "R7");

        // No strobe, no step (R12)
        set_mute(1'b1);
        repeat (30) @(negedge clk);
        set_mute(1'b0);
        send(24'h500000, 24'hB00000, "R12");

        // Zero run at unity (R9, R10)
        set_mute(1'b1);
        while (m_idx != 0) send(24'h000010, 24'h000000, "R3");
        repeat (RUN - 1) send(24'h0, 24'h0, "R9");
        chk(amute_req == 0, "R9", amute_req, 0);
        send(24'h0, 24'h0, "R9");
        chk(amute_req == 1, "R9", amute_req, 1);
        send(24'h0, 24'h000001, "R10");
        chk(amute_req == 0, "R10", amute_req, 0);
        repeat (RUN - 1) send(24'h0, 24'h0, "R9");
        send(24'hFFFFFF, 24'h0, "R10");
        chk(amute_req == 0, "R10", amute_req, 0);

        report();
        $finish;
    end
endmodule